// File: doc/BRIEF.md
# Pipelined 8-bit Accumulator Processor Core

This block is a small processor built around a single 8-bit accumulator. Each instruction word is 16 bits wide. The upper byte selects the operation. The lower byte is an immediate value, a data RAM address or a jump target, depending on the operation. The core fetches from a read-only instruction port and works on a data RAM through a separate read/write port. Visible results go to an 8-bit output register that drives a port directly.

The core has two pipeline stages. In every cycle one word is fetched while the previously fetched word executes. A jump therefore changes the fetch address only after the word behind it has already been fetched, and that word always executes (one delay slot). The accumulator and the output register are clocked every cycle and load under a write enable. An instruction that writes one of them in each of several consecutive cycles leaves each of its values there in turn.

Top module: `acc8_core`

## Requirements
- R1: While `rst` is high at a clock edge, the fetch address becomes 0, the accumulator and `out_q` become 0, and the word in the execute stage becomes a no-operation. After release, the first fetches are 0, 1, 2, … and an output copy of the accumulator yields 0.
- R2: The word is {opcode[15:8], operand[7:0]}. Opcode 0x02 and every opcode byte not listed in R3 to R7 change neither the accumulator nor `out_q`, raise no RAM write, and let the fetch address advance by one.
- R3: Opcode 0x00 loads the operand into the accumulator. Opcode 0x01 loads the accumulator from RAM at the operand address.
- R4: Opcode 0xC2 raises `ram_we` for its execute cycle with `ram_addr` equal to the operand and `ram_wdata` equal to the accumulator, and leaves the accumulator unchanged.
- R5: Opcode 0x81 adds the RAM word at the operand address to the accumulator. Opcode 0xA0 subtracts the operand from it. Both wrap modulo 256, and no flags are kept.
- R6: Opcode 0x18 writes the operand into both the accumulator and `out_q`. Opcode 0x1A copies the accumulator into `out_q`. No other opcode changes `out_q`.
- R7: Opcode 0xFC always jumps to the operand address. Opcode 0xEC jumps when the accumulator is non-zero. Opcode 0xF4 jumps when accumulator bit 7 is 0. The condition is tested on the accumulator as left by all earlier instructions.
- R8: The word after a jump executes whether or not the jump is taken. Seven immediate loads at 0..6 followed by a jump to 0 at 7 repeat the fetch of address 0 every 9 cycles.
- R9: Opcode 0x18 in consecutive cycles with operands 0x11, 0x22, 0x33, 0x44 shows each of these values on `out_q` in four consecutive cycles.
- R10: The Fibonacci program writes 1, 1, 2, 3, 5, 8, 13, 21, 34, 55, 89, 144 to `out_q` and then starts over. Its first output of 1 recurs every 110 cycles.
- R11: A word presented at fetch address A in cycle n executes in cycle n+1. Its register results appear after the edge that ends cycle n+1, and a taken jump sets the fetch address in cycle n+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 8 | Instruction fetch address (registered program counter) |
| imem_data | input | 16 | Instruction word at `imem_addr`, same cycle |
| ram_addr | output | 8 | Data RAM address, taken from the executing word's operand |
| ram_wdata | output | 8 | Data RAM write value (accumulator) |
| ram_we | output | 1 | Data RAM write strobe |
| ram_rdata | input | 8 | Data RAM read value at `ram_addr`, same cycle |
| out_q | output | 8 | Output register |

## Verification
A word fetched in cycle n executes in cycle n+1. Its `ram_we`, `ram_addr` and `ram_wdata` are therefore due during cycle n+1. Its accumulator and `out_q` results are due after the edge closing cycle n+1, and a taken jump's target is due on `imem_addr` in cycle n+2. The bench advances a cycle-level reference model one step per clock and compares all outputs at the falling edge, where every one of those results has settled. Directed checks (period 9, back-to-back output writes, branch outcomes, Fibonacci period 110) count cycles from reset release using the same offsets.

// File: rtl/acc8_pkg.sv
package acc8_pkg;

  localparam logic [7:0] OPC_LDI  = 8'h00;
  localparam logic [7:0] OPC_LDM  = 8'h01;
  localparam logic [7:0] OPC_NOP  = 8'h02;
  localparam logic [7:0] OPC_LDO  = 8'h18;
  localparam logic [7:0] OPC_OUTA = 8'h1A;
  localparam logic [7:0] OPC_ADDM = 8'h81;
  localparam logic [7:0] OPC_SUBI = 8'hA0;
  localparam logic [7:0] OPC_STM  = 8'hC2;
  localparam logic [7:0] OPC_JNZ  = 8'hEC;
  localparam logic [7:0] OPC_JGE  = 8'hF4;
  localparam logic [7:0] OPC_JMP  = 8'hFC;

  typedef enum logic [1:0] {SRC_IMM, SRC_RAM, SRC_ACC} src_e;
  typedef enum logic [1:0] {FN_PASS, FN_ADD, FN_SUB} fn_e;
  typedef enum logic [1:0] {BR_NONE, BR_ALWAYS, BR_NZ, BR_GE} br_e;

  typedef struct packed {
    logic acc_we;
    logic out_we;
    logic mem_we;
    src_e src;
    fn_e  fn;
    br_e  br;
  } ctl_t;

endpackage

// File: rtl/acc8_decode.sv
module acc8_decode
  import acc8_pkg::*;
(
  input  logic [7:0] opc,
  output ctl_t       ctl
);

  always_comb begin
    ctl        = '0;
    ctl.src    = SRC_IMM;
    ctl.fn     = FN_PASS;
    ctl.br     = BR_NONE;
    case (opc)
      OPC_LDI:  ctl.acc_we = 1'b1;
      OPC_LDM:  begin ctl.acc_we = 1'b1; ctl.src = SRC_RAM; end
      OPC_LDO:  begin ctl.acc_we = 1'b1; ctl.out_we = 1'b1; end
      OPC_OUTA: begin ctl.out_we = 1'b1; ctl.src = SRC_ACC; end
      OPC_ADDM: begin ctl.acc_we = 1'b1; ctl.src = SRC_RAM; ctl.fn = FN_ADD; end
      OPC_SUBI: begin ctl.acc_we = 1'b1; ctl.fn = FN_SUB; end
      OPC_STM:  ctl.mem_we = 1'b1;
      OPC_JMP:  ctl.br = BR_ALWAYS;
      OPC_JNZ:  ctl.br = BR_NZ;
      OPC_JGE:  ctl.br = BR_GE;
      default:  ctl = ctl;
    endcase
  end

endmodule

// File: rtl/acc8_alu.sv
module acc8_alu
  import acc8_pkg::*;
#(
  parameter int W = 8
) (
  input  src_e         src,
  input  fn_e          fn,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] imm,
  input  logic [W-1:0] mem,
  output logic [W-1:0] y
);

  logic [W-1:0] b;

  always_comb begin
    case (src)
      SRC_RAM: b = mem;
      SRC_ACC: b = acc;
      default: b = imm;
    endcase
  end

  always_comb begin
    case (fn)
      FN_ADD:  y = acc + b;
      FN_SUB:  y = acc - b;
      default: y = b;
    endcase
  end

endmodule

// File: rtl/acc8_branch.sv
module acc8_branch
  import acc8_pkg::*;
#(
  parameter int W = 8
) (
  input  br_e          br,
  input  logic [W-1:0] acc,
  output logic         take
);

  always_comb begin
    case (br)
      BR_ALWAYS: take = 1'b1;
      BR_NZ:     take = |acc;
      BR_GE:     take = ~acc[W-1];
      default:   take = 1'b0;
    endcase
  end

endmodule

// File: rtl/acc8_fetch.sv
module acc8_fetch #(
  parameter int          AW       = 8,
  parameter int          IW       = 16,
  parameter logic [IW-1:0] NOP_WORD = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic [AW-1:0] target,
  input  logic [IW-1:0] word_in,
  output logic [AW-1:0] pc_q,
  output logic [IW-1:0] ir_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
      ir_q <= NOP_WORD;
    end else begin
      pc_q <= take ? target : pc_q + AW'(1);
      ir_q <= word_in;
    end
  end

endmodule

// File: rtl/acc8_core.sv
module acc8_core
  import acc8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic               clk,
  input  logic               rst,
  output logic [W-1:0]       imem_addr,
  input  logic [8+W-1:0]     imem_data,
  output logic [W-1:0]       ram_addr,
  output logic [W-1:0]       ram_wdata,
  output logic               ram_we,
  input  logic [W-1:0]       ram_rdata,
  output logic [W-1:0]       out_q
);

  localparam int OPW = 8;
  localparam int IW  = OPW + W;
  localparam logic [IW-1:0] NOP_WORD = {OPC_NOP, {W{1'b0}}};

  logic [IW-1:0]  ir_q;
  logic [OPW-1:0] opc;
  logic [W-1:0]   opnd;
  logic [W-1:0]   acc_q;
  logic [W-1:0]   alu_y;
  logic           take;
  ctl_t           ctl;

  assign opc  = ir_q[IW-1 -: OPW];
  assign opnd = ir_q[W-1:0];

  acc8_fetch #(.AW(W), .IW(IW), .NOP_WORD(NOP_WORD)) u_fetch (
    .clk     (clk),
    .rst     (rst),
    .take    (take),
    .target  (opnd),
    .word_in (imem_data),
    .pc_q    (imem_addr),
    .ir_q    (ir_q)
  );

  acc8_decode u_dec (
    .opc (opc),
    .ctl (ctl)
  );

  acc8_alu #(.W(W)) u_alu (
    .src (ctl.src),
    .fn  (ctl.fn),
    .acc (acc_q),
    .imm (opnd),
    .mem (ram_rdata),
    .y   (alu_y)
  );

  acc8_branch #(.W(W)) u_br (
    .br   (ctl.br),
    .acc  (acc_q),
    .take (take)
  );

  // Accumulator and output register: free-running clock, load enable.
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      out_q <= '0;
    end else begin
      if (ctl.acc_we) acc_q <= alu_y;
      if (ctl.out_we) out_q <= alu_y;
    end
  end

  assign ram_addr  = opnd;
  assign ram_wdata = acc_q;
  assign ram_we    = ctl.mem_we;

endmodule

// File: rtl/acc8_core_chk.sv
module acc8_core_chk
  import acc8_pkg::*;
#(
  parameter int W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic [W-1:0]    imem_addr,
  input logic [W-1:0]    out_q,
  input logic [8+W-1:0]  ir_q,
  input logic [W-1:0]    acc_q
);

  logic [7:0]   opc;
  logic [W-1:0] opnd;
  assign opc  = ir_q[8+W-1 -: 8];
  assign opnd = ir_q[W-1:0];

  // R1
  rst_release_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (imem_addr == '0 && out_q == '0 && acc_q == '0));

  // R11
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(opc) != OPC_JMP && $past(opc) != OPC_JNZ && $past(opc) != OPC_JGE)
      |-> imem_addr == $past(imem_addr) + W'(1));

  // R7
  jmp_target_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(opc) == OPC_JMP) |-> imem_addr == $past(opnd));

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(opc) != OPC_LDO && $past(opc) != OPC_OUTA) |-> out_q == $past(out_q));

  // R4
  store_acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(opc) == OPC_STM) |-> acc_q == $past(acc_q));

  // R9
  ldo_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(opc) == OPC_LDO) |-> (out_q == $past(opnd) && acc_q == $past(opnd)));

endmodule

bind acc8_core acc8_core_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .imem_addr (imem_addr),
  .out_q     (out_q),
  .ir_q      (ir_q),
  .acc_q     (acc_q)
);

// File: tb/tb_acc8_core.sv
module tb_acc8_core;

  localparam int W  = 8;
  localparam int IW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [W-1:0]  imem_addr, ram_addr, ram_wdata, ram_rdata, out_q;
  logic [IW-1:0] imem_data;
  logic          ram_we;

  logic [IW-1:0] rom    [256];
  logic [W-1:0]  tb_ram [256];

  assign imem_data = rom[imem_addr];
  assign ram_rdata = tb_ram[ram_addr];
  always @(posedge clk) if (ram_we) tb_ram[ram_addr] <= ram_wdata;

  acc8_core #(.W(W)) dut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we),
    .ram_rdata(ram_rdata), .out_q(out_q)
  );

  // reference model state
  logic [7:0]  m_pc, m_acc, m_out;
  logic [15:0] m_ir;
  logic [7:0]  m_ram [256];
  bit          m_outwr;
  int checks = 0, errors = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_rom();
    for (int i = 0; i < 256; i++) rom[i] = 16'h0200;
  endtask

  task automatic start();
    rst = 1'b1;
    for (int i = 0; i < 256; i++) m_ram[i] = tb_ram[i];
    m_pc = 0; m_ir = 16'h0200; m_acc = 0; m_out = 0; m_outwr = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 out_q in reset", out_q, 0);
    chk("R1 imem_addr in reset", imem_addr, 0);
    rst = 1'b0;
  endtask

  // compare ports at the falling edge, advance the model, move to next falling edge
  task automatic step();
    logic [7:0] op, od, npc;
    bit exp_we;
    op = m_ir[15:8]; od = m_ir[7:0];
    exp_we = (op == 8'hC2);
    chk("R7 R8 R11 imem_addr", imem_addr, m_pc);
    chk("R3 R5 R6 out_q", out_q, m_out);
    chk("R4 ram_we", ram_we, exp_we);
    if (exp_we) begin
      chk("R4 ram_addr", ram_addr, od);
      chk("R4 ram_wdata", ram_wdata, m_acc);
    end
    npc = m_pc + 8'd1;
    m_outwr = 0;
    case (op)
      8'h00: m_acc = od;
      8'h01: m_acc = m_ram[od];
      8'hC2: m_ram[od] = m_acc;
      8'hA0: m_acc = m_acc - od;
      8'h81: m_acc = m_acc + m_ram[od];
      8'h18: begin m_acc = od; m_out = od; m_outwr = 1; end
      8'h1A: begin m_out = m_acc; m_outwr = 1; end
      8'hFC: npc = od;
      8'hEC: if (m_acc != 0) npc = od;
      8'hF4: if (!m_acc[7]) npc = od;
      default: ;
    endcase
    m_ir = rom[m_pc];
    m_pc = npc;
    @(negedge clk);
  endtask

  function automatic logic [15:0] rand_word();
    int k;
    logic [7:0] b;
    k = $urandom_range(0, 11);
    b = 8'($urandom_range(0, 255));
    case (k)
      0: return {8'h00, b};
      1: return {8'h01, 4'h0, b[3:0]};
      2: return {8'hC2, 4'h0, b[3:0]};
      3: return {8'hA0, b};
      4: return {8'h81, 4'h0, b[3:0]};
      5: return {8'h18, b};
      6, 7: return {8'h1A, b};
      8: return {8'hFC, 3'b0, b[4:0]};
      9: return {8'hEC, 3'b0, b[4:0]};
      10: return {8'hF4, 3'b0, b[4:0]};
      default: return {(b[0] ? 8'h77 : 8'h3C), b};
    endcase
  endfunction

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed, zero_at [4], nz, fcnt, fval [16], fcyc [16], cyc;
    int fib [12] = '{1, 1, 2, 3, 5, 8, 13, 21, 34, 55, 89, 144};
    seed = $urandom(32'd20240611);
    for (int i = 0; i < 256; i++) tb_ram[i] = 8'(i * 7 + 3);

    // R1: dirty state, then reset; first instruction copies accumulator out
    clear_rom();
    rom[0] = 16'h185A; rom[1] = 16'hFC01;
    start();
    repeat (6) step();
    chk("R6 out before reset", out_q, 8'h5A);
    clear_rom();
    rom[0] = 16'h1A00;
    start();
    step(); step();
    chk("R1 cleared accumulator via out", out_q, 0);
    chk("R1 fetch sequence after release", imem_addr, 2);

    // R8: seven loads and a jump, period 9
    clear_rom();
    for (int i = 0; i < 7; i++) rom[i] = 16'(i);
    rom[7] = 16'hFC00; rom[8] = 16'h0008;
    start();
    nz = 0;
    for (int c = 0; c < 40; c++) begin
      if (imem_addr == 0 && nz < 4) begin zero_at[nz] = c; nz++; end
      step();
    end
    chk("R8 fetches of address 0", nz, 4);
    for (int i = 1; i < 4; i++) chk("R8 loop period", zero_at[i] - zero_at[i-1], 9);

    // R9: back-to-back output writes
    clear_rom();
    rom[0] = 16'h1811; rom[1] = 16'h1822; rom[2] = 16'h1833; rom[3] = 16'h1844;
    rom[4] = 16'hA001; rom[5] = 16'h1A00;
    start();
    step(); step();
    for (int k = 0; k < 4; k++) begin
      chk("R9 consecutive out capture", out_q, 8'h11 * (k + 1));
      step();
    end
    step();
    chk("R9 R5 accumulator after back-to-back", out_q, 8'h43);

    // R2: unlisted opcodes and 0x02 change nothing
    clear_rom();
    rom[0] = 16'h0005; rom[1] = 16'h7733; rom[2] = 16'h3C99; rom[3] = 16'h0200;
    rom[4] = 16'h1A00;
    start();
    repeat (6) step();
    chk("R2 accumulator kept across unlisted opcodes", out_q, 5);
    chk("R2 sequential fetch", imem_addr, 6);

    // R7: conditional jumps, both outcomes
    clear_rom();
    rom[0] = 16'h0000; rom[1] = 16'hEC10; rom[2] = 16'h0200;
    rom[3] = 16'hF408; rom[4] = 16'h18AA; rom[5] = 16'h18EE;
    rom[8] = 16'hEC0C; rom[9] = 16'h1A00;
    rom[12] = 16'hF420; rom[13] = 16'h1877; rom[14] = 16'h1855;
    rom[15] = 16'hFC0F;
    start();
    repeat (20) step();
    chk("R7 branch outcomes", out_q, 8'h55);
    chk("R7 R8 jump loop address", imem_addr, 15);

    // R10: Fibonacci
    clear_rom();
    rom[0]  = 16'h0000; rom[1]  = 16'hC200; rom[2]  = 16'h0001; rom[3]  = 16'hFC0A;
    rom[4]  = 16'h0200; rom[5]  = 16'h0100; rom[6]  = 16'hC202; rom[7]  = 16'h0101;
    rom[8]  = 16'hC200; rom[9]  = 16'h8102; rom[10] = 16'hC201; rom[11] = 16'h1A00;
    rom[12] = 16'hF405; rom[13] = 16'h0200; rom[14] = 16'hFC00; rom[15] = 16'h0200;
    start();
    fcnt = 0; cyc = 0;
    for (int c = 0; c < 240; c++) begin
      step(); cyc++;
      if (m_outwr && fcnt < 16) begin fval[fcnt] = out_q; fcyc[fcnt] = cyc; fcnt++; end
    end
    chk("R10 output count", (fcnt >= 13) ? 1 : 0, 1);
    for (int i = 0; i < 12; i++) chk("R10 Fibonacci value", fval[i], fib[i]);
    chk("R10 restart value", fval[12], 1);
    chk("R10 restart period", fcyc[12] - fcyc[0], 110);

    // random programs against the model
    for (int p = 0; p < 6; p++) begin
      clear_rom();
      for (int i = 0; i < 32; i++) rom[i] = rand_word();
      for (int i = 0; i < 16; i++) tb_ram[i] = 8'($urandom_range(0, 255));
      start();
      repeat (300) step();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule